// File: doc/BRIEF.md
# Operating-Point Frequency Rounding Search

This block looks up a supported operating point for a requested clock frequency. After a start pulse it walks a table of packed operating-point words through a read port, one word per clock cycle. The table need not be sorted. Each word carries a frequency code and a millivolt value. When the walk finishes, the block pulses done and presents three results. The first is the rounded frequency: the smallest entry at or above the request, or, if no such entry exists, the largest entry below it. The second is that entry's voltage in microvolts. The third is the position of the first entry whose frequency equals the request exactly, with a flag for the case where no entry matches.

A frequency governor would use it in two steps. It first asks for the rounded rate that a request maps to. It then asks for the exact index, which it writes to the performance-level control. The results stay on the outputs until the next accepted start.

Top module: `opp_round_search`

## Requirements
- R1: A table word carries a frequency code in bits [19:0] and millivolts in bits [31:20]. The reported frequency in kHz is code*20, and the reported voltage in microvolts is millivolts*1000.
- R2: If at least one scanned entry is at or above the request, the rounded frequency is the smallest such entry, no matter where it sits in the table.
- R3: If every scanned entry is below the request, the rounded frequency is the largest scanned entry.
- R4: Ties use non-strict compares. When two scanned entries share the winning frequency, the later one in scan order supplies the voltage.
- R5: The match index is the first position whose frequency equals the request. If no scanned entry is equal, not_found is 1 and the match index is 0.
- R6: done is high for exactly one cycle. That cycle is the cycle after the clock edge that lies N edges after the edge that accepts start, where N is the effective count. While the scan runs, done is low.
- R7: With a count of zero, done rises in the cycle right after start, with not_found at 1 and both the rounded frequency and the voltage at 0.
- R8: Only positions 0 to N-1 are read. Entries at or beyond the count never affect any result.
- R9: A start pulse that arrives while a scan is running is ignored. The running scan keeps its timing and its result.
- R10: After reset, done is 0, the rounded frequency and the voltage are 0, and not_found is 1.
- R11: A count above the table depth of 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; accepted only when idle |
| req_khz | input | 25 | Requested frequency in kHz |
| entry_count | input | 4 | Number of valid table entries |
| tbl_addr | output | 3 | Table read position |
| tbl_word | input | 32 | Table word at tbl_addr, same cycle |
| done | output | 1 | One-cycle completion pulse |
| round_khz | output | 25 | Rounded frequency in kHz |
| round_uv | output | 22 | Voltage of the rounded entry in microvolts |
| match_idx | output | 3 | First exact-match position |
| not_found | output | 1 | No exact match among scanned entries |

## Verification
The main function is tried against an unsorted table with several kinds of request. A request that falls between entries shows whether the block picks the smallest entry above it rather than the first one above it in scan order. A request above every entry exercises the fallback to the largest entry below, and a request below every entry confirms that the smallest entry is chosen. An exact-valued request checks the match index. Further patterns cover duplicated frequencies with different voltages, a matching entry placed beyond the count, a full table matched only at the last position, an oversized count, the largest code, and a second start pulse issued in the middle of a scan; these check the tie rule, the count limit, the clamp, the width of the arithmetic and the busy lockout.

// File: rtl/opp_pkg.sv
package opp_pkg;
  localparam int unsigned CODE_W = 20;
  localparam int unsigned MV_W   = 12;
  localparam int unsigned KHZ_W  = 25;
  localparam int unsigned UV_W   = 22;
  localparam int unsigned WORD_W = CODE_W + MV_W;

  typedef struct packed {
    logic [MV_W-1:0]   mv;
    logic [CODE_W-1:0] code;
  } opp_word_t;

  // code * 20 = code*16 + code*4
  function automatic logic [KHZ_W-1:0] code_to_khz(input logic [CODE_W-1:0] c);
    logic [KHZ_W-1:0] w;
    w = {{(KHZ_W-CODE_W){1'b0}}, c};
    return (w << 4) + (w << 2);
  endfunction

  // mv * 1000 = mv*1024 - mv*16 - mv*8
  function automatic logic [UV_W-1:0] mv_to_uv(input logic [MV_W-1:0] m);
    logic [UV_W-1:0] w;
    w = {{(UV_W-MV_W){1'b0}}, m};
    return (w << 10) - (w << 4) - (w << 3);
  endfunction
endpackage

// File: rtl/opp_entry_decode.sv
module opp_entry_decode
  import opp_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [KHZ_W-1:0]  khz_o,
  output logic [MV_W-1:0]   mv_o
);
  opp_word_t w;
  assign w     = opp_word_t'(word_i);
  assign khz_o = code_to_khz(w.code);
  assign mv_o  = w.mv;
endmodule

// File: rtl/opp_best_tracker.sv
module opp_best_tracker
  import opp_pkg::*;
#(
  parameter bit ABOVE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             upd_i,
  input  logic [KHZ_W-1:0] req_i,
  input  logic [KHZ_W-1:0] khz_i,
  input  logic [MV_W-1:0]  mv_i,
  output logic             have_o,
  output logic [KHZ_W-1:0] best_khz_o,
  output logic [MV_W-1:0]  best_mv_o
);
  logic side_ok;
  logic better;
  logic take;

  generate
    if (ABOVE) begin : g_above
      assign side_ok = (khz_i >= req_i);
      assign better  = !have_o || (khz_i <= best_khz_o);
    end else begin : g_below
      assign side_ok = (khz_i < req_i);
      assign better  = !have_o || (khz_i >= best_khz_o);
    end
  endgenerate

  assign take = upd_i && side_ok && better;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_o     <= 1'b0;
      best_khz_o <= '0;
      best_mv_o  <= '0;
    end else if (clear_i) begin
      have_o     <= 1'b0;
      best_khz_o <= '0;
      best_mv_o  <= '0;
    end else if (take) begin
      have_o     <= 1'b1;
      best_khz_o <= khz_i;
      best_mv_o  <= mv_i;
    end
  end

  // R2 R3: during a scan the kept value only moves toward the request
  generate
    if (ABOVE) begin : g_chk_above
      // R2
      assert property (@(posedge clk) disable iff (!rst_n)
        (have_o && !clear_i) |=> (best_khz_o <= $past(best_khz_o)))
        else $error("best_above_monotonic_chk");
    end else begin : g_chk_below
      // R3
      assert property (@(posedge clk) disable iff (!rst_n)
        (have_o && !clear_i) |=> (best_khz_o >= $past(best_khz_o)))
        else $error("best_below_monotonic_chk");
    end
  endgenerate

  // R4: a tying entry replaces the kept voltage
  assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !clear_i && have_o && side_ok && khz_i == best_khz_o) |=> (best_mv_o == $past(mv_i)))
    else $error("tie_replace_chk");
endmodule

// File: rtl/opp_exact_finder.sv
module opp_exact_finder
  import opp_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [KHZ_W-1:0] req_i,
  input  logic [KHZ_W-1:0] khz_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  logic hit;
  assign hit = upd_i && !found_o && (khz_i == req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_o <= 1'b0;
      idx_o   <= '0;
    end else if (clear_i) begin
      found_o <= 1'b0;
      idx_o   <= '0;
    end else if (hit) begin
      found_o <= 1'b1;
      idx_o   <= idx_i;
    end
  end

  // R5: the first match is kept until the next scan starts
  assert property (@(posedge clk) disable iff (!rst_n)
    (found_o && !clear_i) |=> (found_o && $stable(idx_o)))
    else $error("first_match_hold_chk");
endmodule

// File: rtl/opp_round_search.sv
module opp_round_search
  import opp_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 8,
  localparam int unsigned IDX_W = $clog2(MAX_ENTRIES),
  localparam int unsigned CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [KHZ_W-1:0]   req_khz,
  input  logic [CNT_W-1:0]   entry_count,
  output logic [IDX_W-1:0]   tbl_addr,
  input  logic [WORD_W-1:0]  tbl_word,
  output logic               done,
  output logic [KHZ_W-1:0]   round_khz,
  output logic [UV_W-1:0]    round_uv,
  output logic [IDX_W-1:0]   match_idx,
  output logic               not_found
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_ENTRIES);

  logic             busy;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [KHZ_W-1:0] req_q;

  // named internal events
  logic             start_acc;
  logic             last_entry;
  logic [CNT_W-1:0] cnt_eff;

  logic [KHZ_W-1:0] ent_khz;
  logic [MV_W-1:0]  ent_mv;

  logic             hi_have, lo_have, found;
  logic [KHZ_W-1:0] hi_khz, lo_khz;
  logic [MV_W-1:0]  hi_mv, lo_mv;

  assign start_acc  = start && !busy;
  assign cnt_eff    = (entry_count > MAX_CNT) ? MAX_CNT : entry_count;
  assign last_entry = busy && ({1'b0, idx_q} == {1'b0, cnt_q} - 1'b1);
  assign tbl_addr   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx_q <= '0;
      cnt_q <= '0;
      req_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        req_q <= req_khz;
        cnt_q <= cnt_eff;
        idx_q <= '0;
        busy  <= (cnt_eff != '0);
        done  <= (cnt_eff == '0);
      end else if (busy) begin
        idx_q <= idx_q + 1'b1;
        if (last_entry) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  opp_entry_decode u_dec (
    .word_i (tbl_word),
    .khz_o  (ent_khz),
    .mv_o   (ent_mv)
  );

  opp_best_tracker #(.ABOVE(1'b1)) u_hi (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_acc),
    .upd_i      (busy),
    .req_i      (req_q),
    .khz_i      (ent_khz),
    .mv_i       (ent_mv),
    .have_o     (hi_have),
    .best_khz_o (hi_khz),
    .best_mv_o  (hi_mv)
  );

  opp_best_tracker #(.ABOVE(1'b0)) u_lo (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (start_acc),
    .upd_i      (busy),
    .req_i      (req_q),
    .khz_i      (ent_khz),
    .mv_i       (ent_mv),
    .have_o     (lo_have),
    .best_khz_o (lo_khz),
    .best_mv_o  (lo_mv)
  );

  opp_exact_finder #(.IDX_W(IDX_W)) u_exact (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_acc),
    .upd_i   (busy),
    .idx_i   (idx_q),
    .req_i   (req_q),
    .khz_i   (ent_khz),
    .found_o (found),
    .idx_o   (match_idx)
  );

  assign round_khz = hi_have ? hi_khz : (lo_have ? lo_khz : '0);
  assign round_uv  = hi_have ? mv_to_uv(hi_mv) : (lo_have ? mv_to_uv(lo_mv) : '0);
  assign not_found = !found;

  // R6
  assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done)
    else $error("no_done_while_busy_chk");

  // R8
  assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, tbl_addr} < {1'b0, cnt_q}))
    else $error("addr_in_range_chk");

  // R9
  assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(req_q))
    else $error("busy_start_ignored_chk");

  // R2 R3: a result above the request exists only when one was seen
  assert property (@(posedge clk) disable iff (!rst_n)
    (done && round_khz >= req_q && round_khz != '0) |-> hi_have)
    else $error("round_side_chk");
endmodule

// File: tb/opp_round_search_test.sv
module opp_round_search_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [24:0] req_khz = '0;
  logic [3:0]  entry_count = '0;
  logic [2:0]  tbl_addr;
  logic [31:0] tbl_word;
  logic        done;
  logic [24:0] round_khz;
  logic [21:0] round_uv;
  logic [2:0]  match_idx;
  logic        not_found;

  logic [31:0] tbl [8];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign tbl_word = tbl[tbl_addr];

  opp_round_search uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_khz(req_khz),
    .entry_count(entry_count), .tbl_addr(tbl_addr), .tbl_word(tbl_word),
    .done(done), .round_khz(round_khz), .round_uv(round_uv),
    .match_idx(match_idx), .not_found(not_found)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int mv, input int code);
    return {mv[11:0], code[19:0]};
  endfunction

  // reference model written with sentinels and real multiplies
  task automatic ref_model(input longint req, input int n,
                           output longint rk, output longint ruv,
                           output int ridx, output bit rnf);
    longint up_f = 64'h7fffffff, dn_f = -1, up_v = 0, dn_v = 0;
    ridx = 0; rnf = 1;
    for (int i = 0; i < n; i++) begin
      longint f = longint'(tbl[i][19:0]) * 20;
      longint v = longint'(tbl[i][31:20]) * 1000;
      if (f >= req) begin
        if (f <= up_f) begin up_f = f; up_v = v; end
      end else if (f >= dn_f) begin dn_f = f; dn_v = v; end
      if (rnf && f == req) begin rnf = 0; ridx = i; end
    end
    if (up_f != 64'h7fffffff) begin rk = up_f; ruv = up_v; end
    else if (dn_f >= 0) begin rk = dn_f; ruv = dn_v; end
    else begin rk = 0; ruv = 0; end
  endtask

  // one scan: done expected after N further edges, then drops
  task automatic run_scan(input longint req, input int cnt, input bit poke, input string rq);
    longint ek, ev; int ei; bit enf;
    int n = (cnt > 8) ? 8 : cnt;
    ref_model(req, n, ek, ev, ei, enf);
    @(negedge clk);
    start = 1'b1; req_khz = req[24:0]; entry_count = cnt[3:0];
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk(done == 1'b0, {rq, " R6 done early"}, done, 0);
      if (poke && k == 2) begin
        start = 1'b1; req_khz = 25'd1; entry_count = 4'd0;
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1, {rq, " R6 done"}, done, 1);
    chk(round_khz == ek[24:0], {rq, " round_khz"}, round_khz, ek);
    chk(round_uv == ev[21:0], {rq, " R1 round_uv"}, round_uv, ev);
    chk(not_found == enf, {rq, " R5 not_found"}, not_found, enf);
    chk(match_idx == ei[2:0], {rq, " R5 match_idx"}, match_idx, ei);
    @(negedge clk);
    chk(done == 1'b0, {rq, " R6 pulse width"}, done, 0);
  endtask

  task automatic t_reset();
    chk(done == 0, "R10 done", done, 0);
    chk(round_khz == 0, "R10 round_khz", round_khz, 0);
    chk(round_uv == 0, "R10 round_uv", round_uv, 0);
    chk(not_found == 1, "R10 not_found", not_found, 1);
  endtask

  task automatic load_unsorted();
    tbl[0] = mk(950, 30000);  // 600000
    tbl[1] = mk(800, 10000);  // 200000
    tbl[2] = mk(1100, 50000); // 1000000
    tbl[3] = mk(850, 20000);  // 400000
    tbl[4] = mk(1000, 40000); // 800000
    tbl[5] = mk(700, 5000);   // 100000
    tbl[6] = mk(1200, 60000); // 1200000
    tbl[7] = mk(750, 7000);   // 140000
  endtask

  task automatic t_between();
    load_unsorted();
    run_scan(500000, 5, 0, "R2 between");
    chk(round_khz == 25'd600000, "R2 smallest above", round_khz, 600000);
  endtask

  task automatic t_exact();
    run_scan(400000, 5, 0, "R5 exact");
    chk(match_idx == 3'd3, "R5 index", match_idx, 3);
  endtask

  task automatic t_above_all();
    run_scan(2000000, 5, 0, "R3 above all");
    chk(round_khz == 25'd1000000, "R3 largest below", round_khz, 1000000);
  endtask

  task automatic t_below_all();
    run_scan(100, 5, 0, "R2 below all");
  endtask

  task automatic t_count_limit();
    run_scan(1200000, 5, 0, "R8 beyond count");
    chk(not_found == 1'b1, "R8 no match past count", not_found, 1);
    chk(round_khz == 25'd1000000, "R8 round", round_khz, 1000000);
  endtask

  task automatic t_full_last();
    tbl[7] = mk(1234, 7777);
    run_scan(155540, 8, 0, "R5 last index");
    chk(match_idx == 3'd7, "R5 idx7", match_idx, 7);
  endtask

  task automatic t_clamp();
    run_scan(155540, 15, 0, "R11 clamp");
  endtask

  task automatic t_zero();
    run_scan(500000, 0, 0, "R7 zero count");
    chk(round_khz == 0 && round_uv == 0, "R7 zeros", round_khz, 0);
  endtask

  task automatic t_ties();
    tbl[0] = mk(900, 25000);
    tbl[1] = mk(910, 25000);
    tbl[2] = mk(920, 25000);
    tbl[3] = mk(500, 1000);
    tbl[4] = mk(510, 1000);
    run_scan(450000, 5, 0, "R4 tie above");
    chk(round_uv == 22'd920000, "R4 later voltage", round_uv, 920000);
    run_scan(900000, 5, 0, "R4 tie below");
    chk(round_uv == 22'd920000, "R4 later voltage below", round_uv, 920000);
    run_scan(500000, 5, 0, "R5 first of equals");
    chk(match_idx == 3'd0, "R5 first", match_idx, 0);
  endtask

  task automatic t_busy();
    load_unsorted();
    run_scan(700000, 8, 1, "R9 start during scan");
  endtask

  task automatic t_max();
    tbl[0] = mk(4095, 20'hFFFFF);
    run_scan(20971500, 1, 0, "R1 max code");
    chk(round_khz == 25'd20971500, "R1 khz", round_khz, 20971500);
    chk(round_uv == 22'd4095000, "R1 uv", round_uv, 4095000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_between();
    t_exact();
    t_above_all();
    t_below_all();
    t_count_limit();
    t_full_last();
    t_clamp();
    t_zero();
    t_ties();
    t_busy();
    t_max();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule